// File: doc/BRIEF.md
# Three-Channel Up-Counting PWM Timer

This block is a free-running timer with one counter and three compare channels, meant for building simple PWM digital-to-analog outputs. The counter climbs from zero to the value on the period input and then goes back to zero. One full pass is one PWM cycle of `period + 1` counts. Each channel drives a pulse line. The line goes high when the counter leaves the period value and falls once the counter has passed that channel's compare value. The duty in counts therefore follows the compare value, and the DAC resolution in counts is the cycle length divided by the smallest duty step used.

Each channel has its own write strobe and data word. A written value goes into a holding register and becomes active only at the next cycle boundary, so a cycle never gets a truncated or doubled pulse. One use is to refresh one channel from a sine table, step another channel up as a ramp, and leave the third fixed for a steady level. A one-clock strobe marks each cycle boundary, so software or a sequencer knows when to supply the next sample. The counter moves only on clocks where both the enable and the prescale tick are high.

Top module: `tri_pwm_timer`

## Requirements
- R1: On each advancing clock the counter goes up by one. On the advancing clock where it sits at or above `period` it goes to zero, so period-end strobes come exactly `period + 1` advancing clocks apart.
- R2: With `period` = 255 one cycle is 256 counts, and a compare value of 127 gives 128 high counts per cycle.
- R3: Every channel output goes high on the clock at which the counter wraps to zero. This is the same clock on which `period_end` is high.
- R4: For a compare value C below `period`, a channel is high for exactly C + 1 counts of each cycle and low for the rest.
- R5: A compare value of 0 gives a single high count per cycle. A compare value equal to or above `period` keeps the output high for the whole cycle.
- R6: A compare write takes effect only from the first full cycle after the next wrap. A write in mid-cycle leaves the duty of the cycle in progress unchanged.
- R7: `period_end` is high for one clock per advancing wrap, and only while `enable` is high.
- R8: While `enable` is low the counter holds, no `period_end` occurs and all outputs keep their values.
- R9: The counter advances only on clocks where `tick` is high. With `tick` high every second clock, every duty and period measured in clocks doubles.
- R10: Synchronous active-high `rst` drives the outputs and `period_end` low and clears the counter and all compare values. After reset, each channel behaves as if it had compare 0, and its output stays low until the first wrap.
- R11: The three channels are independent. Each uses only its own write port and compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Lets the counter run |
| tick | input | 1 | Prescale clock enable; the counter advances on clocks where it is high |
| period | input | 8 | Last count of each cycle |
| cmp_wr | input | 3 | Per-channel compare write strobe |
| cmp_data | input | 24 | Per-channel compare data, channel k in bits [8k+7:8k] |
| pwm_out | output | 3 | Channel outputs, bit k for channel k |
| period_end | output | 1 | One-clock strobe at each cycle wrap |

## Verification
The assertions assume that `period` changes only rarely compared with the cycle length. They also assume the inputs are driven from time zero, so that their values sampled one clock back are never unknown. The bench changes `period` only between scenarios and then waits two cycle boundaries before it measures anything. It changes inputs on the falling edge and samples outputs on the falling edge before driving. Duty is measured by counting high samples across whole cycles framed by `period_end`, with the compare values written before the frame so the holding registers have already been copied.

// File: rtl/tri_pwm_pkg.sv
package tri_pwm_pkg;

    localparam int unsigned DEF_CNT_W    = 8;
    localparam int unsigned DEF_CHANNELS = 3;

    // Per-clock timing event shared by counter and channels
    typedef struct packed {
        logic step;   // counter advances this clock
        logic wrap;   // counter returns to zero this clock
    } tmr_evt_t;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2
    } pwm_act_t;

    // Set wins over clear, so a compare at or above the period keeps the line high
    function automatic pwm_act_t pick_action(input tmr_evt_t evt, input logic at_cmp);
        pwm_act_t act;
        act = ACT_HOLD;
        if (evt.step) begin
            if (evt.wrap)
                act = ACT_SET;
            else if (at_cmp)
                act = ACT_CLR;
        end
        return act;
    endfunction

endpackage

// File: rtl/pwm_up_counter.sv
module pwm_up_counter
    import tri_pwm_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output tmr_evt_t         evt,
    output logic             period_end
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_comb begin
        evt.step = enable & tick;
        evt.wrap = evt.step & (cnt >= period);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            period_end <= 1'b0;
        end else begin
            period_end <= evt.wrap;
            if (evt.wrap)
                cnt <= '0;
            else if (evt.step)
                cnt <= cnt + ONE;
        end
    end

    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !(enable && tick) |=> $stable(cnt));

    assert_wrap_to_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (enable && tick && cnt >= period) |=> (cnt == '0));

    assert_strobe_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
        period_end |-> $past(enable && tick));

endmodule

// File: rtl/pwm_cmp_channel.sv
module pwm_cmp_channel
    import tri_pwm_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  tmr_evt_t         evt,
    input  logic [CNT_W-1:0] cnt,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm
);

    logic [CNT_W-1:0] shadow_q;
    logic [CNT_W-1:0] active_q;
    pwm_act_t         act;

    always_comb act = pick_action(evt, cnt == active_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active_q <= '0;
            pwm      <= 1'b0;
        end else begin
            if (wr)
                shadow_q <= wr_data;
            if (evt.wrap)
                active_q <= shadow_q;
            case (act)
                ACT_SET: pwm <= 1'b1;
                ACT_CLR: pwm <= 1'b0;
                default: pwm <= pwm;
            endcase
        end
    end

    assert_reload_at_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        !evt.wrap |=> $stable(active_q));

    assert_rise_on_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm) |-> $past(evt.wrap));

    assert_fall_on_match_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(pwm) |-> $past(evt.step && !evt.wrap && cnt == active_q));

endmodule

// File: rtl/tri_pwm_timer.sv
module tri_pwm_timer
    import tri_pwm_pkg::*;
#(
    parameter int unsigned CNT_W    = DEF_CNT_W,
    parameter int unsigned CHANNELS = DEF_CHANNELS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      enable,
    input  logic                      tick,
    input  logic [CNT_W-1:0]          period,
    input  logic [CHANNELS-1:0]       cmp_wr,
    input  logic [CHANNELS*CNT_W-1:0] cmp_data,
    output logic [CHANNELS-1:0]       pwm_out,
    output logic                      period_end
);

    logic [CNT_W-1:0] cnt;
    tmr_evt_t         evt;

    pwm_up_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .tick       (tick),
        .period     (period),
        .cnt        (cnt),
        .evt        (evt),
        .period_end (period_end)
    );

    for (genvar k = 0; k < CHANNELS; k++) begin : g_chan
        pwm_cmp_channel #(.CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .evt     (evt),
            .cnt     (cnt),
            .wr      (cmp_wr[k]),
            .wr_data (cmp_data[k*CNT_W +: CNT_W]),
            .pwm     (pwm_out[k])
        );
    end

    assert_reset_quiet_R10: assert property (@(posedge clk)
        $past(rst) |-> (pwm_out == '0 && !period_end));

    assert_frozen_outputs_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(enable) |-> ($stable(pwm_out) && !period_end));

endmodule

// File: tb/tri_pwm_timer_bench.sv
module tri_pwm_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int NC = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            enable = 1'b0;
    logic            tick = 1'b1;
    logic            tick_div = 1'b0;
    logic [W-1:0]    period = 8'd15;
    logic [NC-1:0]   cmp_wr = '0;
    logic [NC*W-1:0] cmp_data = '0;
    logic [NC-1:0]   pwm_out;
    logic            period_end;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    tri_pwm_timer u_tri_pwm_timer (
        .clk(clk), .rst(rst), .enable(enable), .tick(tick), .period(period),
        .cmp_wr(cmp_wr), .cmp_data(cmp_data), .pwm_out(pwm_out), .period_end(period_end)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (tick_div) tick <= ~tick;
        else          tick <= 1'b1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_cmp(input int ch, input int val);
        @(negedge clk);
        cmp_wr[ch] = 1'b1;
        cmp_data[ch*W +: W] = W'(val);
        @(negedge clk);
        cmp_wr = '0;
    endtask

    task automatic wait_pe();
        @(negedge clk);
        while (!period_end) @(negedge clk);
    endtask

    // Count high samples per channel over len clocks, starting at a period_end
    task automatic measure(input int len, output int hi [NC]);
        for (int c = 0; c < NC; c++) hi[c] = 0;
        wait_pe();
        for (int k = 0; k < len; k++) begin
            if (k > 0) @(negedge clk);
            for (int c = 0; c < NC; c++) if (pwm_out[c]) hi[c]++;
        end
    endtask

    task automatic interval(output int n);
        wait_pe();
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!period_end);
    endtask

    task automatic settle();
        wait_pe();
        wait_pe();
    endtask

    task automatic t_reset();
        int hi [NC];
        chk("R10 outputs in reset", int'(pwm_out), 0);
        chk("R10 period_end in reset", int'(period_end), 0);
        @(negedge clk);
        rst = 1'b0;
        enable = 1'b1;
        @(negedge clk);
        chk("R10 low before first wrap", int'(pwm_out), 0);
        measure(16, hi);
        for (int c = 0; c < NC; c++) chk("R10 cleared compare gives one count", hi[c], 1);
    endtask

    task automatic t_basic();
        int hi [NC];
        int n;
        wr_cmp(0, 3); wr_cmp(1, 8); wr_cmp(2, 0);
        settle();
        measure(16, hi);
        chk("R4 ch0 C=3", hi[0], 4);
        chk("R11 ch1 C=8", hi[1], 9);
        chk("R5 ch2 C=0", hi[2], 1);
        interval(n);
        chk("R1 cycle length P=15", n, 16);
        wait_pe();
        chk("R3 outputs high at wrap", int'(pwm_out), 7);
        @(negedge clk);
        chk("R7 strobe one clock", int'(period_end), 0);
    endtask

    task automatic t_full();
        int hi [NC];
        wr_cmp(0, 15); wr_cmp(1, 200);
        settle();
        measure(16, hi);
        chk("R5 C equal to period", hi[0], 16);
        chk("R5 C above period", hi[1], 16);
        chk("R11 ch2 unchanged", hi[2], 1);
    endtask

    task automatic t_buffer();
        int h0;
        wr_cmp(0, 2);
        settle();
        h0 = 0;
        wait_pe();
        for (int k = 0; k < 16; k++) begin
            if (k > 0) @(negedge clk);
            if (pwm_out[0]) h0++;
            if (k == 1) begin
                cmp_wr[0] = 1'b1;
                cmp_data[0 +: W] = 8'd10;
            end else begin
                cmp_wr = '0;
            end
        end
        chk("R6 mid-cycle write ignored", h0, 3);
        begin
            int hi [NC];
            measure(16, hi);
            chk("R6 new value next cycle", hi[0], 11);
        end
    endtask

    task automatic t_enable();
        logic [NC-1:0] snap;
        int bad;
        bad = 0;
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        snap = pwm_out;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (period_end || pwm_out != snap) bad++;
        end
        chk("R8 frozen while disabled", bad, 0);
        chk("R7 no strobe while disabled", bad, 0);
        enable = 1'b1;
    endtask

    task automatic t_prescale();
        int hi [NC];
        int n;
        wr_cmp(0, 5);
        tick_div = 1'b1;
        settle();
        measure(32, hi);
        chk("R9 duty doubled", hi[0], 12);
        interval(n);
        chk("R9 cycle doubled", n, 32);
        tick_div = 1'b0;
    endtask

    task automatic t_eight_bit();
        int hi [NC];
        int n;
        period = 8'd255;
        wr_cmp(1, 127);
        settle();
        interval(n);
        chk("R2 256-count cycle", n, 256);
        measure(256, hi);
        chk("R2 half duty", hi[1], 128);
        period = 8'd15;
    endtask

    task automatic t_reset_again();
        int hi [NC];
        wr_cmp(0, 9); wr_cmp(1, 9);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R10 mid-run reset outputs", int'(pwm_out), 0);
        rst = 1'b0;
        settle();
        measure(16, hi);
        chk("R10 compare cleared ch0", hi[0], 1);
        chk("R10 compare cleared ch1", hi[1], 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_full();
        t_buffer();
        t_enable();
        t_prescale();
        t_eight_bit();
        t_reset_again();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule